// File: doc/BRIEF.md
# Smart Card Character Transmitter with End-of-Transmission Timing

The block sends single characters toward a smart card over one serial line and decides when to raise the transmit-end flag. Each character is ten elementary time units (etu) long: a low start bit, eight data bits with the least significant bit first, and an even parity bit. After the parity bit the line is released high. While the guard window runs, the block samples the line. If the card pulls the line low there, the block latches an error status. That status keeps the end flag from rising until software clears it.

The point at which the end flag may rise depends on the timing mode. In normal mode it is 12.5 etu after the start bit begins, which is 2.5 etu after the last bit. In GSM mode it is 11.0 etu after the start bit begins. The flag rises only if the data register is empty at that point and no error was seen. Transmit data enters through a valid/ready stream. A byte is taken only when the one-entry data register is empty, transmission is enabled and standby is off. Otherwise `data_ready` stays low and the sender must hold `data_valid` and `data_in` steady. Each accepted byte clears the end flag. The block also drives a card clock pin. In normal mode that pin can only be on or off. In GSM mode it can also be held fixed high or fixed low.

Top module: `sc_tx_end_ctl`

## Requirements
- R1: Reset puts the block in a known state: `tend` is 1, `err_sig` is 0, `tx_line` is 1, `clk_out` is 0 and the data register is empty.
- R2: A character is 10 bits on `tx_line`, each `CLKS_PER_ETU` clocks long. Bit 0 is the start bit (0), bits 1 to 8 carry `data_in[0]` to `data_in[7]`, and bit 9 is the XOR of the eight data bits (even parity). The line is 1 whenever no character is in progress.
- R3: With `gsm_mode`=0, `tend` rises exactly 12.5 etu (25 half-etu) after the first cycle of the start bit.
- R4: With `gsm_mode`=1, `tend` rises exactly 11.0 etu (22 half-etu) after the first cycle of the start bit.
- R5: `data_ready` is 1 exactly when the data register is empty, `tx_en`=1 and `standby`=0. An accepted byte (`data_valid`&&`data_ready` at a clock edge) clears `tend`. If the register was refilled during a character, `tend` does not rise at that character's end point.
- R6: The line is sampled at 10.5 etu. If `line_in` is 0 there, `err_sig` becomes 1 and `tend` does not rise for that character. `err_sig` stays 1 until an `err_clr` pulse.
- R7: While `tx_en`=0 and `err_sig`=0, `tend` is forced to 1. Dropping `tx_en` aborts a character in progress and returns `tx_line` to 1.
- R8: `standby`=1 forces `tend` to 1 and aborts any character in progress.
- R9: `sw_rd_status` while `tend`=1, followed by `sw_wr_zero`, clears `tend`. A `sw_wr_zero` pulse with no such preceding read leaves `tend` unchanged.
- R10: With `gsm_mode`=0, `clk_sel[0]`=1 makes `clk_out` toggle every cycle and `clk_sel[0]`=0 holds it at 0. `clk_sel[1]` has no effect in this mode.
- R11: With `gsm_mode`=1, `clk_sel` works as follows: `x1` toggles the clock every cycle, `00` holds it at 0 and `10` holds it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby request; forces the end flag to 1 and aborts transmission |
| tx_en | input | 1 | Transmit enable |
| gsm_mode | input | 1 | Timing mode: 0 normal (12.5 etu), 1 GSM (11.0 etu) |
| clk_sel | input | 2 | Card clock control |
| data_valid | input | 1 | Transmit byte offered |
| data_ready | output | 1 | Data register can accept a byte |
| data_in | input | 8 | Transmit byte |
| sw_rd_status | input | 1 | Strobe: software read of the end flag |
| sw_wr_zero | input | 1 | Strobe: software write of 0 to the end flag |
| err_clr | input | 1 | Strobe: clear the error status |
| line_in | input | 1 | Sensed level of the shared I/O line |
| tx_line | output | 1 | Level driven onto the I/O line |
| clk_out | output | 1 | Card clock output |
| tend | output | 1 | Transmit-end flag |
| err_sig | output | 1 | Error-signal status from the card |

## Verification
The assertions assume that `gsm_mode` does not change while a character is in progress. They also assume that a refill seen at an end point came from a stream write, not from a byte left over after an abort. The stimulus changes the mode and the clock control only when the block is idle. It writes the second byte of a back-to-back pair only while the first character is running. It performs aborts only after the preceding character's end point has been checked. The card's error pull is applied to `line_in` only across bit 10, so it cannot disturb the data bits.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int unsigned CHAR_BITS = 10;
  localparam int unsigned HPOS_W    = 5;
  localparam logic [HPOS_W-1:0] HPOS_DATA_END = 5'd20;
  localparam logic [HPOS_W-1:0] HPOS_ERR_SMP  = 5'd20;
  localparam logic [HPOS_W-1:0] HPOS_END_NORM = 5'd25;
  localparam logic [HPOS_W-1:0] HPOS_END_GSM  = 5'd22;

  typedef enum logic [1:0] {CK_LOW, CK_HIGH, CK_RUN} ck_mode_e;
endpackage

// File: rtl/sc_half_tick.sv
module sc_half_tick #(
  parameter int unsigned HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       gsm_mode,
  input  logic       tick,
  input  logic       data_valid,
  input  logic       can_accept,
  input  logic [7:0] data_in,
  input  logic       line_in,
  input  logic       err_clr,
  output logic       active,
  output logic       tdr_empty,
  output logic       accept,
  output logic       data_ready,
  output logic       flag_pt,
  output logic       err_sig,
  output logic       tx_line
);
  logic                  active_q, empty_q, err_q;
  logic [HPOS_W-1:0]     hpos_q;
  logic [7:0]            tdr_q;
  logic [CHAR_BITS-1:0]  frame_q;
  logic [HPOS_W-1:0]     end_pos;
  logic [3:0]            bit_idx;
  logic                  start;

  assign end_pos    = gsm_mode ? HPOS_END_GSM : HPOS_END_NORM;
  assign bit_idx    = hpos_q[HPOS_W-1:1];
  assign data_ready = empty_q && can_accept;
  assign accept     = data_valid && data_ready;
  assign start      = !active_q && !empty_q && !abort;
  assign flag_pt    = active_q && !abort && tick && (hpos_q == end_pos - 1'b1);
  assign tx_line    = (active_q && hpos_q < HPOS_DATA_END) ? frame_q[bit_idx] : 1'b1;
  assign active     = active_q;
  assign tdr_empty  = empty_q;
  assign err_sig    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      hpos_q   <= '0;
      frame_q  <= '1;
    end else if (abort) begin
      active_q <= 1'b0;
      hpos_q   <= '0;
    end else if (active_q) begin
      if (tick) hpos_q <= hpos_q + 1'b1;
      if (flag_pt) active_q <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      hpos_q   <= '0;
      frame_q  <= {^tdr_q, tdr_q, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      tdr_q   <= '0;
    end else if (accept) begin
      empty_q <= 1'b0;
      tdr_q   <= data_in;
    end else if (start) begin
      empty_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  err_q <= 1'b0;
    else if (err_clr) err_q <= 1'b0;
    else if (active_q && !abort && tick && hpos_q == HPOS_ERR_SMP && !line_in)
      err_q <= 1'b1;
  end

  // R2: a character always opens with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> !tx_line);
  // R5: a taken byte fills the register, so the stream stalls next cycle
  a_r5_stall_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !data_ready);
endmodule

// File: rtl/sc_tend_flag.sv
module sc_tend_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic tx_en,
  input  logic err_sig,
  input  logic flag_pt,
  input  logic tdr_empty,
  input  logic accept,
  input  logic sw_rd_status,
  input  logic sw_wr_zero,
  output logic tend
);
  logic tend_q, armed_q;

  assign tend = tend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
    end else if (standby) begin
      tend_q <= 1'b1;
    end else if (!tx_en && !err_sig) begin
      tend_q <= 1'b1;
    end else if (flag_pt && tdr_empty && !err_sig) begin
      tend_q <= 1'b1;
    end else if (accept || (armed_q && sw_wr_zero)) begin
      tend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       armed_q <= 1'b0;
    else if (standby || sw_wr_zero)   armed_q <= 1'b0;
    else if (sw_rd_status && tend_q)  armed_q <= 1'b1;
  end

  // R5: a refilled data register keeps the flag low at the end point
  a_r5_refill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pt && !tdr_empty && tx_en && !standby |=> !tend_q);
  // R6: a latched card error keeps the flag from rising
  a_r6_error_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pt && err_sig && tx_en && !standby |=> !$rose(tend_q));
endmodule

// File: rtl/sc_card_clk.sv
module sc_card_clk
  import sc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gsm_mode,
  input  logic [1:0] clk_sel,
  output logic       clk_out
);
  ck_mode_e mode;
  logic     out_q;

  always_comb begin
    if (clk_sel[0])      mode = CK_RUN;
    else if (!gsm_mode)  mode = CK_LOW;
    else if (clk_sel[1]) mode = CK_HIGH;
    else                 mode = CK_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else begin
      unique case (mode)
        CK_RUN:  out_q <= ~out_q;
        CK_HIGH: out_q <= 1'b1;
        default: out_q <= 1'b0;
      endcase
    end
  end

  assign clk_out = out_q;

  // R10: in normal mode a stopped clock rests low whatever bit 1 says
  a_r10_normal_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    !gsm_mode && !clk_sel[0] |=> !clk_out);
  // R11: GSM fixed-high setting holds the pin at 1
  a_r11_gsm_fixed_high: assert property (@(posedge clk) disable iff (!rst_n)
    gsm_mode && clk_sel == 2'b10 |=> clk_out);
endmodule

// File: rtl/sc_tx_end_ctl.sv
module sc_tx_end_ctl
  import sc_tx_pkg::*;
#(
  parameter int unsigned CLKS_PER_ETU = 372
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       tx_en,
  input  logic       gsm_mode,
  input  logic [1:0] clk_sel,
  input  logic       data_valid,
  output logic       data_ready,
  input  logic [7:0] data_in,
  input  logic       sw_rd_status,
  input  logic       sw_wr_zero,
  input  logic       err_clr,
  input  logic       line_in,
  output logic       tx_line,
  output logic       clk_out,
  output logic       tend,
  output logic       err_sig
);
  localparam int unsigned HALF_CLKS = CLKS_PER_ETU / 2;

  logic abort, active, tick, tdr_empty, accept, flag_pt;

  assign abort = standby || !tx_en;

  sc_half_tick #(.HALF_CLKS(HALF_CLKS)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active && !abort), .tick(tick)
  );

  sc_char_tx u_char (
    .clk(clk), .rst_n(rst_n), .abort(abort), .gsm_mode(gsm_mode), .tick(tick),
    .data_valid(data_valid), .can_accept(!abort), .data_in(data_in),
    .line_in(line_in), .err_clr(err_clr), .active(active),
    .tdr_empty(tdr_empty), .accept(accept), .data_ready(data_ready),
    .flag_pt(flag_pt), .err_sig(err_sig), .tx_line(tx_line)
  );

  sc_tend_flag u_flag (
    .clk(clk), .rst_n(rst_n), .standby(standby), .tx_en(tx_en),
    .err_sig(err_sig), .flag_pt(flag_pt), .tdr_empty(tdr_empty),
    .accept(accept), .sw_rd_status(sw_rd_status), .sw_wr_zero(sw_wr_zero),
    .tend(tend)
  );

  sc_card_clk u_clk (
    .clk(clk), .rst_n(rst_n), .gsm_mode(gsm_mode), .clk_sel(clk_sel),
    .clk_out(clk_out)
  );

  // R8: standby always leaves the flag set on the following cycle
  a_r8_standby_sets: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> tend);
  // R7: an abort returns the line to idle high
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> tx_line);
endmodule

// File: tb/sc_tx_end_ctl_bench.sv
module sc_tx_end_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ETU = 8;
  localparam int H = ETU / 2;

  typedef struct {
    logic [9:0] bits;
    logic       gsm;
    logic       err_inj;
    logic       exp_rise;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic standby = 0, tx_en = 0, gsm_mode = 0;
  logic [1:0] clk_sel = 2'b00;
  logic data_valid = 0;
  logic [7:0] data_in = '0;
  logic sw_rd_status = 0, sw_wr_zero = 0, err_clr = 0;
  logic pull = 0;
  logic line_in, data_ready, tx_line, clk_out, tend, err_sig;
  logic mon_busy = 0;
  int n_chk = 0, n_fail = 0;
  item_t q[$];

  assign line_in = tx_line & ~pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_tx_end_ctl #(.CLKS_PER_ETU(ETU)) u_sc_tx_end_ctl (
    .clk(clk), .rst_n(rst_n), .standby(standby), .tx_en(tx_en),
    .gsm_mode(gsm_mode), .clk_sel(clk_sel), .data_valid(data_valid),
    .data_ready(data_ready), .data_in(data_in), .sw_rd_status(sw_rd_status),
    .sw_wr_zero(sw_wr_zero), .err_clr(err_clr), .line_in(line_in),
    .tx_line(tx_line), .clk_out(clk_out), .tend(tend), .err_sig(err_sig)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver: offers a byte on the stream and records what the line must show
  task automatic send(input logic [7:0] d, input logic inj, input logic rise, input logic track);
    item_t it;
    it.bits = {^d, d, 1'b0};
    it.gsm = gsm_mode;
    it.err_inj = inj;
    it.exp_rise = rise;
    if (track) q.push_back(it);
    @(negedge clk);
    data_valid = 1;
    data_in = d;
    for (int w = 0; w < 1000 && !data_ready; w++) @(negedge clk);
    @(negedge clk);
    data_valid = 0;
  endtask

  task automatic wait_idle();
    for (int w = 0; w < 5000; w++) begin
      @(negedge clk);
      if (q.size() == 0 && !mon_busy) break;
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  // monitor: pops expected characters and compares the line and the flag
  initial begin
    logic prev = 1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx_line && q.size() > 0) begin
        item_t it;
        int t;
        it = q.pop_front();
        mon_busy = 1;
        t = it.gsm ? 22 : 25;
        chk(tend == 0, "R5 write clears flag", tend, 0);
        for (int c = 1; c <= t * H; c++) begin
          @(negedge clk);
          if (c < 20 * H && (c % (2 * H)) == H)
            chk(tx_line == it.bits[c / (2 * H)], "R2 bit value", tx_line, it.bits[c / (2 * H)]);
          if (it.err_inj && c == 20 * H) pull = 1;
          if (c == 22 * H) pull = 0;
          if (it.exp_rise && c == t * H - 1)
            chk(tend == 0, it.gsm ? "R4 flag early" : "R3 flag early", tend, 0);
          if (c == t * H)
            chk(tend == it.exp_rise, it.gsm ? "R4 flag at 11.0 etu" : "R3/R5/R6 flag at end point",
                tend, it.exp_rise);
        end
        mon_busy = 0;
      end
      prev = tx_line;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tend == 1, "R1 tend", tend, 1);
    chk(err_sig == 0, "R1 err_sig", err_sig, 0);
    chk(tx_line == 1, "R1 tx_line", tx_line, 1);
    chk(clk_out == 0, "R1 clk_out", clk_out, 0);
    chk(data_ready == 0, "R5 ready low without tx_en", data_ready, 0);
    tx_en = 1;
    @(negedge clk);
    chk(data_ready == 1, "R5 ready when empty", data_ready, 1);

    // R3 normal timing, R2 framing
    send(8'hA5, 0, 1, 1);
    wait_idle();
    // R4 GSM timing
    gsm_mode = 1;
    send(8'h3C, 0, 1, 1);
    wait_idle();
    gsm_mode = 0;

    // R5 refill during a character blocks the first end point
    send(8'h81, 0, 0, 1);
    repeat (10) @(negedge clk);
    send(8'h7E, 0, 1, 1);
    wait_idle();

    // R6 card error pull
    send(8'h55, 1, 0, 1);
    wait_idle();
    chk(err_sig == 1, "R6 err latched", err_sig, 1);
    repeat (5) @(negedge clk);
    chk(tend == 0, "R6 flag held low", tend, 0);
    pulse(err_clr);
    @(negedge clk);
    chk(err_sig == 0, "R6 err cleared", err_sig, 0);

    // R9 software clear sequence
    send(8'h0F, 0, 1, 1);
    wait_idle();
    pulse(sw_wr_zero);
    @(negedge clk);
    chk(tend == 1, "R9 write without read ignored", tend, 1);
    pulse(sw_rd_status);
    pulse(sw_wr_zero);
    @(negedge clk);
    chk(tend == 0, "R9 read then write clears", tend, 0);

    // R7 force and abort
    @(negedge clk); tx_en = 0;
    @(negedge clk);
    chk(tend == 1, "R7 forced with tx_en low", tend, 1);
    chk(data_ready == 0, "R5 ready low without tx_en", data_ready, 0);
    tx_en = 1;
    send(8'h00, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk(tx_line == 0, "R7 character running", tx_line, 0);
    tx_en = 0;
    repeat (2) @(negedge clk);
    chk(tx_line == 1, "R7 abort idles line", tx_line, 1);
    chk(tend == 1, "R7 flag forced", tend, 1);
    tx_en = 1;
    repeat (2) @(negedge clk);

    // R8 standby
    send(8'h00, 0, 0, 0);
    repeat (20) @(negedge clk);
    chk(tend == 0, "R8 flag low before standby", tend, 0);
    standby = 1;
    repeat (2) @(negedge clk);
    chk(tend == 1, "R8 standby sets flag", tend, 1);
    chk(tx_line == 1, "R8 standby aborts", tx_line, 1);
    chk(data_ready == 0, "R5 ready low in standby", data_ready, 0);
    standby = 0;
    @(negedge clk);

    // R10/R11 card clock control
    for (int g = 0; g < 2; g++) begin
      for (int s = 0; s < 4; s++) begin
        logic a, b, run;
        logic lvl;
        gsm_mode = g[0];
        clk_sel = s[1:0];
        repeat (3) @(negedge clk);
        a = clk_out;
        @(negedge clk);
        b = clk_out;
        run = s[0];
        lvl = g[0] ? s[1] : 1'b0;
        if (run) chk(a != b, g ? "R11 clock running" : "R10 clock running", b, !a);
        else chk(a == lvl && b == lvl, g ? "R11 clock fixed level" : "R10 clock stopped", b, lvl);
      end
    end
    finish_run();
  end
endmodule